// File: doc/BRIEF.md
# Half-Duplex Command/Data SPI Master

This block is an SPI master for serial-flash-style traffic. Software programs it over a small 32-bit register bus. One start runs a three-phase transaction in SPI mode 0. The first phase shifts command bits out of an opcode word. The second shifts transmit bits out of a data buffer. The third captures receive bits from MISO back into the same buffer. Each phase has its own bit count, and any phase whose count is zero is skipped. The select lines are software controlled, so a device stays selected across as many transactions as software wants.

The serial clock is the system clock divided by an integer from 2 to 4097. The divisor is programmed as its value minus two. A control bit chooses whether each byte travels LSB first or MSB first. The opcode word goes out most-significant byte first. Buffer words are little-endian byte streams: byte 0 is bits 7:0 of word 0. While a transaction runs, the block freezes its setup registers against bus writes. The select register can still be written at any time.

Top module: `hdx_spi_master`

## Requirements
- R1: After reset, every register reads zero, `spi_sck` and `spi_mosi` are low, and every `spi_cs_n` line is high.
- R2: Writing a word with bit 8 set to offset 0x00 starts a transaction, and bit 16 of offset 0x00 reads 1 while it runs. The transaction stays busy for exactly N·D cycles, where N is the total bit count and D the divisor. With N = 0 it is busy for one cycle and `spi_sck` never toggles.
- R3: Control offset 0x28 holds D−2 in bits 27:16, so reset gives D = 2. Each SCK period lasts D cycles, of which floor(D/2) are high. SCK idles low. MOSI changes only while SCK is low, and MISO is sampled as SCK rises.
- R4: Count offset 0x2C holds the command bits in 31:24, the receive bits in 20:12 and the transmit bits in 8:0. A command count above 32 acts as 32, and a transmit or receive count above 256 acts as 256. Exactly N SCK pulses are produced, with N = command + transmit + receive.
- R5: Command bits come from the opcode word at offset 0x04, taking bits 31:24 first, then 23:16, and so on. With a command count of zero the opcode is not sent at all.
- R6: Transmit bits follow the command bits. They come from the buffer words at 0x08 + 4·w, w = 0..7, in byte order: byte b is bits 8(b mod 4)+7 : 8(b mod 4) of word b/4.
- R7: Receive bits follow the transmit bits. They fill the buffer with the same byte packing. Bits not reached by the receive count keep their previous value.
- R8: Bit 3 of the control register set means each byte is sent and received LSB first. Clear means MSB first. The setting applies in all three phases.
- R9: MOSI is low during the receive phase and whenever no transaction runs.
- R10: Select offset 0x30 has one bit per device. A set bit drives that device's `spi_cs_n` low from the cycle after the write, and this holds even while busy.
- R11: While busy, writes to every register other than the select register are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address (word aligned) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low device selects |

## Verification
Some properties are checked on every cycle. SCK and MOSI stay low while idle. MOSI holds still whenever SCK is high. SCK rises only inside a transaction. An empty transaction ends after one cycle. The select lines follow every select write. The opcode register does not move under a write made while busy.

Other behaviour only the bench scenarios can show, using a behavioural slave across a range of divisors and counts:
- command and data byte order, in both bit orders;
- phase order, and saturation of oversized counts;
- receive packing into partially filled bytes;
- the exact busy length and SCK high time;
- that a second start during a transaction does not restart it.

// File: rtl/hdx_spi_pkg.sv
package hdx_spi_pkg;

   // opcode word width, fixed by the register bus
   localparam int OP_BITS   = 32;
   // count register field positions
   localparam int CMD_LSB   = 24;
   localparam int RX_LSB    = 12;
   localparam int TX_LSB    = 0;
   localparam int FIELD_W   = 9;
   localparam int CMD_W     = 8;
   // control register fields
   localparam int DIV_LSB   = 16;
   localparam int LSB_BIT   = 3;
   // transaction register fields
   localparam int GO_BIT    = 8;
   localparam int BUSY_BIT  = 16;

   // choose bit j of a byte in the selected order
   function automatic logic pick_bit(input logic [7:0] byte_v,
                                     input logic [2:0] j,
                                     input logic       lsb_first);
      return lsb_first ? byte_v[j] : byte_v[~j];
   endfunction

endpackage

// File: rtl/hdx_spi_clkgen.sv
module hdx_spi_clkgen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div_m2,
   output logic             sck,
   output logic             rise_now,
   output logic             fall_now
);
   localparam int PER_W = DIV_W + 1;

   logic [PER_W-1:0] period, hi_len, lo_len, cnt_q;

   assign period = PER_W'(div_m2) + PER_W'(2);
   assign hi_len = period >> 1;
   assign lo_len = period - hi_len;

   assign rise_now = active && !sck && (cnt_q == '0);
   assign fall_now = active &&  sck && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck   <= 1'b0;
         cnt_q <= '0;
      end else if (!active) begin
         sck   <= 1'b0;
         cnt_q <= lo_len - PER_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - PER_W'(1);
      end else if (!sck) begin
         sck   <= 1'b1;
         cnt_q <= hi_len - PER_W'(1);
      end else begin
         sck   <= 1'b0;
         cnt_q <= lo_len - PER_W'(1);
      end
   end

endmodule

// File: rtl/hdx_spi_seq.sv
module hdx_spi_seq
   import hdx_spi_pkg::*;
#(
   parameter int BUF_BITS = 256,
   parameter int CMD_MAX  = 32
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic [$clog2(CMD_MAX+1)-1:0]           cmd_bits,
   input  logic [$clog2(BUF_BITS+1)-1:0]          tx_bits,
   input  logic [$clog2(BUF_BITS+1)-1:0]          rx_bits,
   input  logic [OP_BITS-1:0]                     opcode,
   input  logic [BUF_BITS-1:0]                    dbuf,
   input  logic                                   lsb_first,
   input  logic                                   rise_now,
   input  logic                                   fall_now,
   output logic                                   busy,
   output logic                                   active,
   output logic                                   mosi,
   output logic                                   rx_we,
   output logic [$clog2(BUF_BITS)-1:0]            rx_pos
);
   localparam int IDX_W  = $clog2(CMD_MAX + 2*BUF_BITS + 1);
   localparam int BPOS_W = $clog2(BUF_BITS);

   logic [IDX_W-1:0]  bidx_q, nb, total, cmd_end, tx_end, t_ofs, r_ofs;
   logic [7:0]        nb_byte;
   logic [2:0]        nb_j;
   logic              nxt_bit, in_rx;

   assign cmd_end = IDX_W'(cmd_bits);
   assign tx_end  = cmd_end + IDX_W'(tx_bits);
   assign total   = tx_end + IDX_W'(rx_bits);
   assign active  = busy && (total != '0);

   // next outgoing bit: index 0 at start, else the following bit
   always_comb begin
      nb      = busy ? bidx_q + IDX_W'(1) : '0;
      t_ofs   = nb - cmd_end;
      nb_byte = '0;
      nb_j    = '0;
      if (nb < cmd_end) begin
         nb_byte = opcode[{~nb[4:3], 3'b000} +: 8];
         nb_j    = nb[2:0];
      end else if (nb < tx_end) begin
         nb_byte = dbuf[{t_ofs[BPOS_W-1:3], 3'b000} +: 8];
         nb_j    = t_ofs[2:0];
      end
      nxt_bit = (nb < tx_end) ? pick_bit(nb_byte, nb_j, lsb_first) : 1'b0;
   end

   // receive placement of the bit currently sampled
   assign r_ofs  = bidx_q - tx_end;
   assign in_rx  = (bidx_q >= tx_end);
   assign rx_we  = rise_now && in_rx;
   assign rx_pos = {r_ofs[BPOS_W-1:3], lsb_first ? r_ofs[2:0] : ~r_ofs[2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         bidx_q <= '0;
         mosi   <= 1'b0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         bidx_q <= '0;
         mosi   <= nxt_bit;
      end else if (busy) begin
         if (total == '0) begin
            busy <= 1'b0;
         end else if (fall_now) begin
            if (bidx_q == total - IDX_W'(1)) begin
               busy   <= 1'b0;
               bidx_q <= '0;
               mosi   <= 1'b0;
            end else begin
               bidx_q <= bidx_q + IDX_W'(1);
               mosi   <= nxt_bit;
            end
         end
      end
   end

endmodule

// File: rtl/hdx_spi_master.sv
module hdx_spi_master
   import hdx_spi_pkg::*;
#(
   parameter int NUM_CS    = 2,
   parameter int BUF_WORDS = 8,
   parameter int DIV_W     = 12,
   parameter int ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   localparam int BUF_BITS = 32 * BUF_WORDS;
   localparam int CMD_MAX  = OP_BITS;
   localparam int CNT_W    = $clog2(BUF_BITS + 1);
   localparam int CMDC_W   = $clog2(CMD_MAX + 1);
   localparam int BPOS_W   = $clog2(BUF_BITS);
   localparam int WI_W     = ADDR_W - 2;
   localparam int W_TRANS  = 0;
   localparam int W_OPC    = 1;
   localparam int W_BUF    = 2;
   localparam int W_CTRL   = W_BUF + BUF_WORDS;
   localparam int W_CNT    = W_CTRL + 1;
   localparam int W_CS     = W_CTRL + 2;
   localparam logic [FIELD_W-1:0] BUF_LIM = FIELD_W'(BUF_BITS);
   localparam logic [CMD_W-1:0]   CMD_LIM = CMD_W'(CMD_MAX);

   // elaboration-time parameter checks
   if (NUM_CS < 1 || NUM_CS > 32) begin : g_bad_cs
      $error("NUM_CS out of range");
   end
   if (BUF_WORDS < 2 || BUF_WORDS > 8 || (BUF_WORDS & (BUF_WORDS-1)) != 0) begin : g_bad_buf
      $error("BUF_WORDS must be a power of two from 2 to 8");
   end
   if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
      $error("DIV_W must fit the 12-bit divisor field");
   end
   if (W_CS >= (1 << WI_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [WI_W-1:0]      widx;
   logic                 unused_addr;
   logic                 busy, active, wr_ok, start, cs_we, opc_req;
   logic [OP_BITS-1:0]   opcode_q;
   logic [DIV_W-1:0]     div_q;
   logic                 lsb_q;
   logic [CMD_W-1:0]     cmd_raw;
   logic [FIELD_W-1:0]   tx_raw, rx_raw;
   logic [NUM_CS-1:0]    cs_q;
   logic [BUF_BITS-1:0]  dbuf;
   logic [CMDC_W-1:0]    cmd_eff;
   logic [CNT_W-1:0]     tx_eff, rx_eff;
   logic                 rise_now, fall_now, rx_we;
   logic [BPOS_W-1:0]    rx_pos;
   logic [31:0]          ctrl_rd, cnt_rd, cs_rd;

   assign widx        = bus_addr[ADDR_W-1:2];
   assign unused_addr = ^bus_addr[1:0];
   assign wr_ok       = bus_we && !busy;
   assign start       = wr_ok && (widx == WI_W'(W_TRANS)) && bus_wdata[GO_BIT];
   assign cs_we       = bus_we && (widx == WI_W'(W_CS));
   assign opc_req     = bus_we && (widx == WI_W'(W_OPC));

   // oversized counts saturate at the phase limits
   assign cmd_eff = (cmd_raw > CMD_LIM) ? CMDC_W'(CMD_MAX)  : CMDC_W'(cmd_raw);
   assign tx_eff  = (tx_raw  > BUF_LIM) ? CNT_W'(BUF_BITS)  : CNT_W'(tx_raw);
   assign rx_eff  = (rx_raw  > BUF_LIM) ? CNT_W'(BUF_BITS)  : CNT_W'(rx_raw);

   // setup registers, frozen while busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         div_q    <= '0;
         lsb_q    <= 1'b0;
         cmd_raw  <= '0;
         tx_raw   <= '0;
         rx_raw   <= '0;
      end else if (wr_ok) begin
         if (widx == WI_W'(W_OPC))  opcode_q <= bus_wdata;
         if (widx == WI_W'(W_CTRL)) begin
            div_q <= bus_wdata[DIV_LSB +: DIV_W];
            lsb_q <= bus_wdata[LSB_BIT];
         end
         if (widx == WI_W'(W_CNT)) begin
            cmd_raw <= bus_wdata[CMD_LSB +: CMD_W];
            rx_raw  <= bus_wdata[RX_LSB  +: FIELD_W];
            tx_raw  <= bus_wdata[TX_LSB  +: FIELD_W];
         end
      end
   end

   // select register, writable at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cs_q <= '0;
      else if (cs_we) cs_q <= bus_wdata[NUM_CS-1:0];
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign spi_cs_n[i] = ~cs_q[i];
   end

   // data buffer: bus word writes and receive bit writes
   for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_ok && widx == WI_W'(W_BUF + w)) begin
            word_q <= bus_wdata;
         end else if (rx_we && rx_pos[BPOS_W-1:5] == (BPOS_W-5)'(w)) begin
            word_q[rx_pos[4:0]] <= spi_miso;
         end
      end
      assign dbuf[32*w +: 32] = word_q;
   end

   // read-back
   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[DIV_LSB +: DIV_W] = div_q;
      ctrl_rd[LSB_BIT]          = lsb_q;
      cnt_rd = '0;
      cnt_rd[CMD_LSB +: CMD_W]   = cmd_raw;
      cnt_rd[RX_LSB  +: FIELD_W] = rx_raw;
      cnt_rd[TX_LSB  +: FIELD_W] = tx_raw;
      cs_rd = '0;
      cs_rd[NUM_CS-1:0] = cs_q;
      bus_rdata = '0;
      if (widx == WI_W'(W_TRANS)) bus_rdata[BUSY_BIT] = busy;
      if (widx == WI_W'(W_OPC))   bus_rdata = opcode_q;
      if (widx == WI_W'(W_CTRL))  bus_rdata = ctrl_rd;
      if (widx == WI_W'(W_CNT))   bus_rdata = cnt_rd;
      if (widx == WI_W'(W_CS))    bus_rdata = cs_rd;
      for (int w = 0; w < BUF_WORDS; w++) begin
         if (widx == WI_W'(W_BUF + w)) bus_rdata = dbuf[32*w +: 32];
      end
   end

   hdx_spi_clkgen #(.DIV_W(DIV_W)) clkgen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .div_m2   (div_q),
      .sck      (spi_sck),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   hdx_spi_seq #(.BUF_BITS(BUF_BITS), .CMD_MAX(CMD_MAX)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd_bits  (cmd_eff),
      .tx_bits   (tx_eff),
      .rx_bits   (rx_eff),
      .opcode    (opcode_q),
      .dbuf      (dbuf),
      .lsb_first (lsb_q),
      .rise_now  (rise_now),
      .fall_now  (fall_now),
      .busy      (busy),
      .active    (active),
      .mosi      (spi_mosi),
      .rx_we     (rx_we),
      .rx_pos    (rx_pos)
   );

endmodule

// File: rtl/hdx_spi_master_chk.sv
module hdx_spi_master_chk #(
   parameter int NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              active,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs_n,
   input logic              cs_we,
   input logic              opc_req,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       opcode_q
);

   // R3
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);

   // R3
   mosi_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> $stable(spi_mosi));

   // R9
   mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_mosi);

   // R2
   sck_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> busy);

   // R2
   empty_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !active) |=> !busy);

   // R10
   cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_we |=> (spi_cs_n == ~$past(bus_wdata[NUM_CS-1:0])));

   // R11
   opc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && opc_req) |=> $stable(opcode_q));

endmodule

bind hdx_spi_master hdx_spi_master_chk #(.NUM_CS(NUM_CS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .active    (active),
   .spi_sck   (spi_sck),
   .spi_mosi  (spi_mosi),
   .spi_cs_n  (spi_cs_n),
   .cs_we     (cs_we),
   .opc_req   (opc_req),
   .bus_wdata (bus_wdata),
   .opcode_q  (opcode_q)
);

// File: tb/hdx_spi_master_tb_top.sv
module hdx_spi_master_tb_top;

   localparam logic [5:0] A_TRANS = 6'h00;
   localparam logic [5:0] A_OPC   = 6'h04;
   localparam logic [5:0] A_BUF   = 6'h08;
   localparam logic [5:0] A_CTRL  = 6'h28;
   localparam logic [5:0] A_CNT   = 6'h2C;
   localparam logic [5:0] A_CS    = 6'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_miso;
   logic [1:0]  spi_cs_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   hdx_spi_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   // ---------------- behavioural slave ----------------
   int  rise_cnt = 0;
   int  rx_start_b = 0;
   bit  lsb_b = 1'b0;
   bit  cap [0:1023];
   wire cs_any = &spi_cs_n;

   function automatic logic [7:0] rx_byte(input int k);
      return 8'((k * 29 + 90) & 255);
   endfunction

   function automatic bit rx_bit(input int n, input bit lsb);
      logic [7:0] b;
      if (n < 0) return 1'b0;
      b = rx_byte(n / 8);
      return lsb ? b[n % 8] : b[7 - (n % 8)];
   endfunction

   assign spi_miso = rx_bit(rise_cnt - rx_start_b, lsb_b);

   always @(posedge spi_sck or negedge cs_any) begin
      if (spi_sck) begin
         cap[rise_cnt] = spi_mosi;
         rise_cnt = rise_cnt + 1;
      end else begin
         rise_cnt = 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // one transaction with full checking
   task automatic run(input int cmd_f, input int tx_f, input int rx_f,
                      input int divm2, input bit lsb, input int dev,
                      input logic [31:0] opc, input int seed, input bit meddle);
      int cmd_e, tx_e, rx_e, n_bits, d, busy_cnt, hi_cnt, mism, it;
      logic [255:0] mbuf;
      logic [31:0]  rd, ctrl_w, cnt_w;
      bit exp_b [0:1023];
      bit b;
      cmd_e  = (cmd_f > 32)  ? 32  : cmd_f;
      tx_e   = (tx_f  > 256) ? 256 : tx_f;
      rx_e   = (rx_f  > 256) ? 256 : rx_f;
      n_bits = cmd_e + tx_e + rx_e;
      d      = divm2 + 2;
      for (int w = 0; w < 8; w++)
         mbuf[32*w +: 32] = (32'(seed) * 32'h01010101) ^ (32'(w) * 32'h10204081);
      // expected MOSI stream
      for (int n = 0; n < n_bits; n++) begin
         logic [7:0] by;
         int k, j;
         if (n < cmd_e) begin
            k = n / 8; j = n % 8; by = opc[31 - 8*k -: 8];
            exp_b[n] = lsb ? by[j] : by[7-j];
         end else if (n < cmd_e + tx_e) begin
            k = (n - cmd_e) / 8; j = (n - cmd_e) % 8; by = mbuf[8*k +: 8];
            exp_b[n] = lsb ? by[j] : by[7-j];
         end else begin
            exp_b[n] = 1'b0;
         end
      end
      ctrl_w = (32'(divm2) << 16) | (lsb ? 32'h8 : 32'h0);
      cnt_w  = (32'(cmd_f) << 24) | (32'(rx_f) << 12) | 32'(tx_f);
      bus_write(A_CTRL, ctrl_w);
      bus_write(A_CNT, cnt_w);
      bus_write(A_OPC, opc);
      for (int w = 0; w < 8; w++) bus_write(A_BUF + 6'(4*w), mbuf[32*w +: 32]);
      lsb_b = lsb;
      rx_start_b = cmd_e + tx_e;
      bus_write(A_CS, 32'(1) << dev);
      check(spi_cs_n == ~(2'(1) << dev), "R10", "select low", spi_cs_n, ~(2'(1) << dev));
      // start and poll
      busy_cnt = 0; hi_cnt = 0; it = 0;
      bus_addr = A_TRANS; bus_wdata = 32'h100; bus_we = 1'b1;
      do begin
         @(negedge clk);
         bus_we = 1'b0;
         if (meddle && it == 3) begin
            bus_write(A_OPC, ~opc);
            bus_write(A_CTRL, 32'h0FFF_0000);
            bus_write(A_CNT, 32'h0);
            bus_write(A_BUF, 32'hDEAD_BEEF);
            bus_write(A_TRANS, 32'h100);
            bus_write(A_CS, 32'h3);
            check(spi_cs_n == 2'b00, "R10", "select write while busy", spi_cs_n, 0);
            bus_write(A_CS, 32'(1) << dev);
         end
         bus_addr = A_TRANS;
         #1;
         b = bus_rdata[16];
         if (b) busy_cnt++;
         if (spi_sck) hi_cnt++;
         it++;
      end while (b && it < 40000);
      if (!meddle) begin
         check(busy_cnt == ((n_bits == 0) ? 1 : n_bits * d), "R2", "busy cycles",
               busy_cnt, (n_bits == 0) ? 1 : n_bits * d);
         check(hi_cnt == n_bits * (d / 2), "R3", "sck high cycles", hi_cnt, n_bits * (d / 2));
      end
      check(rise_cnt == n_bits, "R4", "sck pulses", rise_cnt, n_bits);
      mism = 0;
      for (int n = 0; n < n_bits; n++) if (cap[n] != exp_b[n]) mism++;
      check(mism == 0, "R5 R6 R8 R9", "mosi bit mismatches", mism, 0);
      check(spi_mosi == 1'b0 && spi_sck == 1'b0, "R9", "idle mosi/sck", {spi_sck, spi_mosi}, 0);
      // expected buffer after receive
      for (int n = 0; n < rx_e; n++) begin
         int k, j;
         k = n / 8; j = n % 8;
         mbuf[8*k + (lsb ? j : 7 - j)] = rx_bit(n, lsb);
      end
      for (int w = 0; w < 8; w++) begin
         bus_read(A_BUF + 6'(4*w), rd);
         check(rd == mbuf[32*w +: 32], "R7", "buffer word", rd, mbuf[32*w +: 32]);
      end
      if (meddle) begin
         bus_read(A_OPC, rd);
         check(rd == opc, "R11", "opcode kept", rd, opc);
         bus_read(A_CTRL, rd);
         check(rd == ctrl_w, "R11", "control kept", rd, ctrl_w);
         bus_read(A_CNT, rd);
         check(rd == cnt_w, "R11", "counts kept", rd, cnt_w);
      end
      @(negedge clk);
      bus_write(A_CS, 32'h0);
      check(spi_cs_n == 2'b11, "R10", "deselect", spi_cs_n, 3);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1", "sck/mosi at reset", {spi_sck, spi_mosi}, 0);
      check(spi_cs_n == 2'b11, "R1", "selects at reset", spi_cs_n, 3);
      bus_read(A_TRANS, rd); check(rd == 0, "R1", "trans reg", rd, 0);
      bus_read(A_OPC, rd);   check(rd == 0, "R1", "opcode reg", rd, 0);
      bus_read(A_CTRL, rd);  check(rd == 0, "R1", "control reg", rd, 0);
      bus_read(A_CNT, rd);   check(rd == 0, "R1", "count reg", rd, 0);
      bus_read(A_CS, rd);    check(rd == 0, "R1", "select reg", rd, 0);
      bus_read(A_BUF, rd);   check(rd == 0, "R1", "buffer word 0", rd, 0);

      run(8,   16,  16,   0,    0, 0, 32'hA5C3_0F81, 1, 0);   // R5 R6 R7 basic
      run(32,  0,   24,   1,    0, 1, 32'h1234_5678, 2, 0);   // R3 odd divisor, R5 full opcode
      run(0,   24,  8,    5,    1, 0, 32'hFFFF_FFFF, 3, 0);   // R5 no command, R8 LSB first
      run(12,  5,   11,   2,    0, 1, 32'h9C3E_71B2, 4, 0);   // R7 partial bytes
      run(32,  256, 0,    0,    0, 0, 32'h0F1E_2D3C, 5, 0);   // R6 full buffer out
      run(0,   0,   256,  1,    1, 1, 32'h0,         6, 0);   // R7 R8 full buffer in
      run(40,  300, 0,    0,    1, 0, 32'h8001_7FFE, 7, 0);   // R4 saturation
      run(0,   0,   0,    3,    0, 0, 32'h5555_AAAA, 8, 0);   // R2 empty transaction
      run(200, 0,   300,  0,    0, 1, 32'hC001_D00D, 9, 0);   // R4 cmd and rx saturation
      run(8,   0,   0,    4095, 0, 0, 32'h6900_0000, 10, 0);  // R3 largest divisor
      run(16,  64,  32,   2,    0, 0, 32'hBEEF_1234, 11, 1);  // R11 R10 writes while busy

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule